// File: doc/BRIEF.md
# Instruction Prefix Address Extender

This block keeps a short-lived prefix for the instruction that follows a prefix write. The core writes a 16-bit value and a 3-bit bank index in one execution cycle. For the next execution cycle only, the block does three things:

- it presents the low byte of that value as the high-order immediate byte;
- it widens the next instruction's 4-bit source field into a 5-bit register address;
- it widens the next instruction's 3-bit destination field into a 5-bit register address.

At the end of that execution cycle the value and the index fall back to zero. A read port always shows the held 16-bit value.

An execution strobe marks the cycles in which an instruction completes. The held state changes only on those cycles, so a stalled core sees the prefix stay in place. The write side is a plain strobed port with no back-pressure. A write offered while the strobe is low is not accepted and has no effect. The address fields are combinational pass-through paths, so the decoder gets widened addresses in the same cycle it presents the fields.

Top module: `pfx_addr_ext`

## Requirements
- R1: After reset, the read data and the immediate byte are 0, and the index is 0 (source addresses 00h–0Fh, destination addresses 00h–07h).
- R2: A write accepted on a cycle with the execution strobe high appears on the read port after that clock edge. The full 16 bits appear whatever index is used, because every index reaches the same register.
- R3: The immediate byte output always equals bits 7:0 of the held value.
- R4: On an execution-strobe cycle with no write, the held value and the index return to 0 at that edge.
- R5: While the execution strobe is low, the held value and the index do not change, and a write offered in such a cycle is ignored.
- R6: The source address is {index bit 0, source field}: odd indices select 10h–1Fh and even indices select 00h–0Fh.
- R7: The destination address is {index bits 2:1, destination field}. Indices 0/1, 2/3, 4/5 and 6/7 select 00h–07h, 08h–0Fh, 10h–17h and 18h–1Fh.
- R8: A write on an execution-strobe cycle that directly follows another write replaces both the value and the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_stb | input | 1 | High on cycles where an instruction completes |
| wr_en | input | 1 | Prefix write request |
| wr_idx | input | 3 | Bank index of the write |
| wr_data | input | 16 | Value to write |
| rd_data | output | 16 | Held prefix value |
| imm_hi | output | 8 | High-order immediate byte for the next instruction |
| src_fld | input | 4 | Source field of the next instruction |
| dst_fld | input | 3 | Destination field of the next instruction |
| src_addr | output | 5 | Widened source register address |
| dst_addr | output | 5 | Widened destination register address |

## Verification
The bench writes a different value at each of the eight indices. After each write it sweeps every source and destination field, so a swapped index bit or a wrong bank assignment shows up as an address in the wrong 8- or 16-register range.

It then checks three timing cases:
- Expiry: a design that leaves the prefix live for more than one execution cycle keeps a nonzero value or a raised bank.
- Stall: a design that counts raw clocks instead of strobes clears the prefix during the stall, or takes a write offered while stalled.
- Back-to-back writes: a design that merges two consecutive writes shows the old index alongside the new value.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int unsigned PFX_DATA_W   = 16;
  localparam int unsigned PFX_IMM_W    = 8;
  localparam int unsigned PFX_IDX_W    = 3;
  localparam int unsigned PFX_SRC_W    = 4;
  localparam int unsigned PFX_DST_W    = 3;
  localparam int unsigned PFX_SRCBNK_W = 1;
endpackage

// File: rtl/pfx_hold_reg.sv
module pfx_hold_reg #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_stb,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] held_data,
  output logic [IDX_W-1:0]  held_idx,
  output logic              live
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_data <= '0;
      held_idx  <= '0;
      live      <= 1'b0;
    end else if (exec_stb) begin
      if (wr_en) begin
        held_data <= wr_data;
        held_idx  <= wr_idx;
        live      <= 1'b1;
      end else begin
        held_data <= '0;
        held_idx  <= '0;
        live      <= 1'b0;
      end
    end
  end

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stb && wr_en) |=> (held_data == $past(wr_data) && held_idx == $past(wr_idx))); // R2
  AST_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_stb && !wr_en) |=> (held_data == '0 && held_idx == '0)); // R4
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_stb && $past(rst_n)) |=> ($stable(held_data) && $stable(held_idx))); // R5
endmodule

// File: rtl/pfx_addr_map.sv
module pfx_addr_map #(
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned SRC_W    = 4,
  parameter int unsigned DST_W    = 3,
  parameter int unsigned SRCBNK_W = 1,
  localparam int unsigned DSTBNK_W = IDX_W - SRCBNK_W,
  localparam int unsigned SADDR_W  = SRC_W + SRCBNK_W,
  localparam int unsigned DADDR_W  = DST_W + DSTBNK_W
) (
  input  logic [IDX_W-1:0]   idx,
  input  logic [SRC_W-1:0]   src_fld,
  input  logic [DST_W-1:0]   dst_fld,
  output logic [SADDR_W-1:0] src_addr,
  output logic [DADDR_W-1:0] dst_addr
);
  generate
    if (SRCBNK_W == 0) begin : g_no_src_bank
      assign src_addr = src_fld;
      assign dst_addr = {idx, dst_fld};
    end else begin : g_split_bank
      assign src_addr = {idx[SRCBNK_W-1:0], src_fld};
      assign dst_addr = {idx[IDX_W-1:SRCBNK_W], dst_fld};
    end
  endgenerate
endmodule

// File: rtl/pfx_addr_ext.sv
module pfx_addr_ext
  import pfx_pkg::*;
#(
  parameter int unsigned DATA_W   = PFX_DATA_W,
  parameter int unsigned IMM_W    = PFX_IMM_W,
  parameter int unsigned IDX_W    = PFX_IDX_W,
  parameter int unsigned SRC_W    = PFX_SRC_W,
  parameter int unsigned DST_W    = PFX_DST_W,
  parameter int unsigned SRCBNK_W = PFX_SRCBNK_W,
  localparam int unsigned SADDR_W = SRC_W + SRCBNK_W,
  localparam int unsigned DADDR_W = DST_W + IDX_W - SRCBNK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exec_stb,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  rd_data,
  output logic [IMM_W-1:0]   imm_hi,
  input  logic [SRC_W-1:0]   src_fld,
  input  logic [DST_W-1:0]   dst_fld,
  output logic [SADDR_W-1:0] src_addr,
  output logic [DADDR_W-1:0] dst_addr
);
  logic [DATA_W-1:0] held_data;
  logic [IDX_W-1:0]  held_idx;
  logic              live;

  pfx_hold_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data),
    .held_data(held_data), .held_idx(held_idx), .live(live)
  );

  pfx_addr_map #(.IDX_W(IDX_W), .SRC_W(SRC_W), .DST_W(DST_W), .SRCBNK_W(SRCBNK_W)) u_map (
    .idx(held_idx), .src_fld(src_fld), .dst_fld(dst_fld),
    .src_addr(src_addr), .dst_addr(dst_addr)
  );

  assign rd_data = held_data;
  assign imm_hi  = held_data[IMM_W-1:0];

  AST_IDLE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> (src_addr[SADDR_W-1:SRC_W] == '0 && dst_addr[DADDR_W-1:DST_W] == '0)); // R1
  AST_IDLE_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> (imm_hi == '0 && rd_data == '0)); // R3
endmodule

// File: tb/test_pfx_addr_ext.sv
module test_pfx_addr_ext;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_stb = 1'b0, wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  src_fld = '0;
  logic [2:0]  dst_fld = '0;
  logic [15:0] rd_data;
  logic [7:0]  imm_hi;
  logic [4:0]  src_addr, dst_addr;

  int n_chk = 0, n_fail = 0;
  logic [15:0] e_val = '0;
  logic [2:0]  e_idx = '0;

  always #10 clk = ~clk;

  pfx_addr_ext i_pfx_addr_ext (
    .clk(clk), .rst_n(rst_n), .exec_stb(exec_stb), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .rd_data(rd_data), .imm_hi(imm_hi),
    .src_fld(src_fld), .dst_fld(dst_fld), .src_addr(src_addr), .dst_addr(dst_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: inputs set at a falling edge, model updated, back at next falling edge
  task automatic cyc(input logic stb, input logic we, input logic [2:0] ix, input logic [15:0] d);
    exec_stb = stb; wr_en = we; wr_idx = ix; wr_data = d;
    @(negedge clk);
    if (stb) begin
      e_val = we ? d : 16'h0;
      e_idx = we ? ix : 3'd0;
    end
  endtask

  task automatic chk_val(input string req);
    chk(req, rd_data, e_val);
    chk({req, "_imm"}, imm_hi, e_val[7:0]);
  endtask

  task automatic sweep_addr();
    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 8; d++) begin
        src_fld = 4'(s); dst_fld = 3'(d);
        #1;
        chk("R6", src_addr, (e_idx % 2) * 16 + s);
        chk("R7", dst_addr, (e_idx / 2) * 8 + d);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", rd_data, 0);
    chk("R1", imm_hi, 0);
    sweep_addr();

    // R2 R3 R6 R7 R4: every index, then expiry
    for (int i = 0; i < 8; i++) begin
      logic [15:0] v;
      v = 16'hA5C3 ^ 16'(i * 16'h1357) ^ 16'(i << 12);
      cyc(1'b1, 1'b1, 3'(i), v);
      chk_val("R2");
      chk("R3", imm_hi, v[7:0]);
      sweep_addr();
      cyc(1'b1, 1'b0, 3'd7, 16'hFFFF);
      chk_val("R4");
      chk("R4", rd_data, 0);
      sweep_addr();
    end

    // R5 stall keeps prefix and ignores writes
    cyc(1'b1, 1'b1, 3'd5, 16'h7E81);
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 1'b1, 3'd2, 16'h0F0F);
      chk("R5", rd_data, 16'h7E81);
      chk("R5", imm_hi, 8'h81);
      sweep_addr();
    end
    cyc(1'b0, 1'b0, 3'd0, 16'h0);
    chk("R5", rd_data, 16'h7E81);
    cyc(1'b1, 1'b0, 3'd0, 16'h0);
    chk("R4", rd_data, 0);
    // R5 stalled write while idle is ignored
    cyc(1'b0, 1'b1, 3'd7, 16'hBEEF);
    chk("R5", rd_data, 0);
    sweep_addr();

    // R8 back-to-back writes replace value and index
    cyc(1'b1, 1'b1, 3'd3, 16'h1122);
    chk("R8", rd_data, 16'h1122);
    cyc(1'b1, 1'b1, 3'd6, 16'h3344);
    chk("R8", rd_data, 16'h3344);
    chk("R8", imm_hi, 8'h44);
    src_fld = 4'hA; dst_fld = 3'd5; #1;
    chk("R8", src_addr, 5'h0A);
    chk("R8", dst_addr, 5'h1D);
    sweep_addr();
    cyc(1'b1, 1'b0, 3'd0, 16'h0);
    chk("R4", rd_data, 0);
    sweep_addr();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule